// File: doc/BRIEF.md
# Configurable serial frame transmitter

This block turns characters into asynchronous serial frames on a single output line. Characters are written into a sixteen-entry transmit queue. A serialiser takes them out one at a time and sends each as a start bit, the data bits with the least significant bit first, an optional parity bit and then one or two stop bits. A separate baud generator supplies a one-cycle pulse once per bit time. The serialiser advances by exactly one bit on each pulse, so each bit lasts one pulse interval.

A mode word selects the frame format: the character length, the parity rule and the number of stop bits. The mode word is sampled at the moment a frame is loaded, so changing it never corrupts a frame that is already on the line. The control inputs work as follows:

- An enable level and a disable level gate the transmitter. Disable has priority.
- A pair of pulses starts and ends a break, which holds the line low.
- A transmit reset pulse clears the queue and the frame in flight.

Two flags report whether the queue is empty or full.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, `serial_out` is 1, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: A frame is a 0 start bit, then the data bits LSB first, then the parity bit when enabled, then the stop bits at 1. Each bit is held from one `baud_tick` to the next. The first bit appears on the cycle after the tick that loads the frame. The next queued frame follows without an idle bit time.
- R3: `mode_word[2:1]` sets the character length: 10 gives 7 bits, 11 gives 6 bits, and 00 or 01 gives 8 bits.
- R4: `mode_word[5:3]` sets the parity bit. 000 makes the count of ones over data and parity even. 001 makes that count odd. 010 always sends 0. 011 always sends 1. Any value 1xx sends no parity bit.
- R5: `mode_word[7:6]` equal to 10 sends two stop bits. Every other value sends one.
- R6: A new frame starts only while `tx_enable` is 1 and `tx_disable` is 0. While `tx_disable` is 1, the line stays high and the queue keeps its contents, even if `tx_enable` is 1.
- R7: If `tx_disable` rises during a frame, that frame finishes. The line then idles high and no further frame starts.
- R8: A `break_start` pulse drives the line low from the next cycle on and discards any frame in progress. A `break_stop` pulse returns the line high on the next cycle. When both pulses arrive together, stop wins.
- R9: A `tx_reset` pulse empties the queue, abandons the current frame and ends any break. On the next cycle `fifo_empty` is 1 and the line is high.
- R10: The queue holds 16 characters. `fifo_full` is 1 at 16 entries and `fifo_empty` is 1 at zero entries. A write into a full queue is dropped unless a pop happens in the same cycle.
- R11: A write on the same cycle that the serialiser pops a full queue is accepted, so the queue stays full.
- R12: Characters of 6 or 7 bits use only the low bits of the queued entry. The upper bits affect neither the data nor the parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 7 | Frame format bits [7:1]: length [2:1], parity [5:3], stop [7:6] |
| tx_enable | input | 1 | Transmitter enable level |
| tx_disable | input | 1 | Transmitter disable level, overrides enable |
| break_start | input | 1 | Pulse: begin holding the line low |
| break_stop | input | 1 | Pulse: release the break |
| tx_reset | input | 1 | Pulse: clear queue and serialiser |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_valid | input | 1 | Write strobe for the queue |
| wr_char | input | 8 | Character to queue |
| serial_out | output | 1 | Serial line, idle high |
| fifo_empty | output | 1 | Queue holds no characters |
| fifo_full | output | 1 | Queue holds 16 characters |

## Verification
Two functions can land on the same cycle: a write into the full queue, and the serialiser popping that queue on a baud tick. To provoke this, the bench fills the queue while the transmitter is disabled. It then releases the disable and issues a write on the exact cycle whose tick loads the first frame. The outcome is judged in two ways. The full flag must stay set after that edge. The scoreboard must then see seventeen frames in write order, with none lost or repeated. A second same-cycle case drives the break start and break stop pulses together, and the line must be high on the next cycle.

// File: rtl/uft_pkg.sv
// Shared types and the frame builder for the serial frame transmitter.
// Assumes characters are at most 8 bits and frames at most 12 bits long.
package uft_pkg;

    localparam int CHAR_W  = 8;
    localparam int FRAME_W = 12;
    localparam int LEN_W   = 4;

    typedef struct packed {
        logic [FRAME_W-1:0] bits;  // bit 0 goes out first
        logic [LEN_W-1:0]   len;   // number of bit times in the frame
    } frame_t;

    // Builds the complete frame for one character under the given format.
    function automatic frame_t uft_make_frame(input logic [CHAR_W-1:0] ch,
                                              input logic [7:1] mode);
        frame_t              f;
        int                  nd;
        logic [CHAR_W-1:0]   low_mask;
        logic [CHAR_W-1:0]   dm;
        logic                pb;
        logic                par_on;
        logic                two_stop;
        case (mode[2:1])
            2'b10:   nd = 7;
            2'b11:   nd = 6;
            default: nd = 8;
        endcase
        low_mask = 8'hFF >> (8 - nd);
        dm       = ch & low_mask;
        case (mode[4:3])
            2'b00:   pb = ^dm;
            2'b01:   pb = ~^dm;
            2'b10:   pb = 1'b0;
            default: pb = 1'b1;
        endcase
        par_on   = ~mode[5];
        two_stop = mode[7] & ~mode[6];
        f.bits      = '1;
        f.bits[0]   = 1'b0;
        f.bits[8:1] = dm | ~low_mask;
        if (par_on && !pb)
            f.bits = f.bits & ~(12'd1 << (nd + 1));
        f.len = LEN_W'(1 + nd + (par_on ? 1 : 0) + (two_stop ? 2 : 1));
        return f;
    endfunction

endpackage

// File: rtl/uft_fifo.sv
// Character queue for the transmitter. Clear takes priority over all traffic.
// A push into a full queue succeeds only when a pop happens in the same cycle.
// The caller must not pop an empty queue; such pops are ignored.
module uft_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    rd_ptr;
    logic [AW-1:0]    wr_ptr;
    logic [CW-1:0]    count;
    logic             push_ok;
    logic             pop_ok;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Decide which requests take effect this cycle.
    always_comb begin
        pop_ok  = pop && !empty;
        push_ok = push && (!full || pop_ok);
    end

    // Store an accepted character.
    always_ff @(posedge clk) begin
        if (push_ok && !clr)
            mem[wr_ptr] <= din;
    end

    // Track pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the head entry and the occupancy flags.
    always_comb begin
        dout  = mem[rd_ptr];
        empty = (count == '0);
        full  = (count == CW'(DEPTH));
    end

endmodule

// File: rtl/uft_ctrl.sv
// Control gating for the transmitter. The run level is enable and not disable.
// The break flag is set by start, cleared by stop or transmit reset; stop wins.
module uft_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_enable,
    input  logic tx_disable,
    input  logic break_start,
    input  logic break_stop,
    input  logic tx_reset,
    output logic run,
    output logic brk
);
    // Hold the break state between the start and stop pulses.
    always_ff @(posedge clk) begin
        if (!rst_n || tx_reset || break_stop)
            brk <= 1'b0;
        else if (break_start)
            brk <= 1'b1;
    end

    // Disable overrides enable.
    always_comb run = tx_enable && !tx_disable;

endmodule

// File: rtl/uft_ser.sv
// Serialiser: loads a prebuilt frame on a baud tick and shifts one bit per
// tick. It assumes baud_tick is a single-cycle pulse. A new frame is loaded
// only when the run level is set, no break is active and the queue has data.
// The load can happen on the tick that ends the previous frame.
module uft_ser
    import uft_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              brk,
    input  logic              run,
    input  logic              tick,
    input  logic [7:1]        mode,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_head,
    output logic              q_pop,
    output logic              busy,
    output logic              line
);
    logic [FRAME_W-1:0] fr;
    logic [LEN_W-1:0]   left;
    logic               can_load;
    logic               slot_free;
    frame_t             nxt;

    // Build the candidate frame and decide whether it loads this tick.
    always_comb begin
        nxt       = uft_make_frame(q_head, mode);
        slot_free = !busy || (left == LEN_W'(1));
        can_load  = run && !brk && !q_empty && !clr;
        q_pop     = tick && slot_free && can_load;
    end

    // Shift the frame out one bit per tick and chain the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || brk) begin
            busy <= 1'b0;
            left <= '0;
            fr   <= '1;
        end else if (tick) begin
            if (busy && left > LEN_W'(1)) begin
                fr   <= {1'b1, fr[FRAME_W-1:1]};
                left <= left - 1'b1;
            end else if (can_load) begin
                fr   <= nxt.bits;
                left <= nxt.len;
                busy <= 1'b1;
            end else begin
                busy <= 1'b0;
                fr   <= '1;
            end
        end
    end

    // Break forces low; otherwise the current bit or idle high.
    always_comb line = brk ? 1'b0 : (busy ? fr[0] : 1'b1);

endmodule

// File: rtl/uart_frame_tx.sv
// Top of the serial frame transmitter: queue, control gating and serialiser.
// It assumes an external generator pulses baud_tick once per bit time.
module uart_frame_tx #(
    parameter int FIFO_DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:1] mode_word,
    input  logic       tx_enable,
    input  logic       tx_disable,
    input  logic       break_start,
    input  logic       break_stop,
    input  logic       tx_reset,
    input  logic       baud_tick,
    input  logic       wr_valid,
    input  logic [7:0] wr_char,
    output logic       serial_out,
    output logic       fifo_empty,
    output logic       fifo_full
);
    import uft_pkg::*;

    logic              run_on;
    logic              brk_on;
    logic              q_pop;
    logic [CHAR_W-1:0] q_head;
    logic              ser_busy;

    uft_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_enable   (tx_enable),
        .tx_disable  (tx_disable),
        .break_start (break_start),
        .break_stop  (break_stop),
        .tx_reset    (tx_reset),
        .run         (run_on),
        .brk         (brk_on)
    );

    uft_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (CHAR_W)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tx_reset),
        .push  (wr_valid),
        .din   (wr_char),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    uft_ser u_ser (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tx_reset),
        .brk     (brk_on),
        .run     (run_on),
        .tick    (baud_tick),
        .mode    (mode_word),
        .q_empty (fifo_empty),
        .q_head  (q_head),
        .q_pop   (q_pop),
        .busy    (ser_busy),
        .line    (serial_out)
    );

endmodule

// File: rtl/uft_chk.sv
// Property checker for the serial frame transmitter, attached by bind.
module uft_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_disable,
    input logic break_start,
    input logic break_stop,
    input logic tx_reset,
    input logic serial_out,
    input logic fifo_empty,
    input logic fifo_full,
    input logic ser_busy,
    input logic brk_on
);
    // R8
    brk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (break_start && !break_stop && !tx_reset) |=> !serial_out);

    // R8
    brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (break_stop && brk_on) |=> serial_out);

    // R9
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset |=> (fifo_empty && serial_out));

    // R10
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_empty && fifo_full));

    // R6
    dis_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_disable |=> !$rose(ser_busy));

endmodule

bind uart_frame_tx uft_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_disable  (tx_disable),
    .break_start (break_start),
    .break_stop  (break_stop),
    .tx_reset    (tx_reset),
    .serial_out  (serial_out),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .ser_busy    (ser_busy),
    .brk_on      (brk_on)
);

// File: tb/tb_uart_frame_tx.sv
// Scoreboard bench: the driver queues expected frames, the monitor samples
// the line after every baud tick and compares whole frames.
module tb_uart_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode_cfg = 8'h20;
    logic       tx_enable = 1'b0;
    logic       tx_disable = 1'b0;
    logic       break_start = 1'b0;
    logic       break_stop = 1'b0;
    logic       tx_reset = 1'b0;
    logic       tick_on = 1'b0;
    logic       baud_tick;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_char = 8'h00;
    logic       serial_out;
    logic       fifo_empty;
    logic       fifo_full;

    int         cyc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         mon_en = 1'b0;
    string      cur_req = "R2";
    logic [11:0] exp_bits_q[$];
    int          exp_len_q[$];

    always #5 clk = ~clk;

    // Bench-side baud generator: one pulse every 8 cycles.
    always @(negedge clk) cyc <= cyc + 1;
    assign baud_tick = tick_on && (cyc % 8 == 0);

    uart_frame_tx dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_word   (mode_cfg[7:1]),
        .tx_enable   (tx_enable),
        .tx_disable  (tx_disable),
        .break_start (break_start),
        .break_stop  (break_stop),
        .tx_reset    (tx_reset),
        .baud_tick   (baud_tick),
        .wr_valid    (wr_valid),
        .wr_char     (wr_char),
        .serial_out  (serial_out),
        .fifo_empty  (fifo_empty),
        .fifo_full   (fifo_full)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Reference frame model written from the requirements.
    task automatic model(input logic [7:0] d, input logic [7:0] m,
                         output logic [11:0] b, output int len);
        int nb;
        int ones;
        logic p;
        nb = (m[2:1] == 2'b11) ? 6 : ((m[2:1] == 2'b10) ? 7 : 8);
        b = '1;
        ones = 0;
        b[0] = 1'b0;
        len = 1;
        for (int k = 0; k < nb; k++) begin
            b[len] = d[k];
            ones += int'(d[k]);
            len++;
        end
        if (!m[5]) begin
            case (m[4:3])
                2'b00:   p = (ones % 2) == 1;
                2'b01:   p = (ones % 2) == 0;
                2'b10:   p = 1'b0;
                default: p = 1'b1;
            endcase
            b[len] = p;
            len++;
        end
        len += (m[7:6] == 2'b10) ? 2 : 1;
    endtask

    // Driver: writes one character and records the frame it should produce.
    task automatic put(input logic [7:0] d, input bit expect_sent);
        logic [11:0] b;
        int          l;
        step();
        wr_valid = 1'b1;
        wr_char  = d;
        if (expect_sent) begin
            model(d, mode_cfg, b, l);
            exp_bits_q.push_back(b);
            exp_len_q.push_back(l);
        end
        step();
        wr_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while ((exp_len_q.size() != 0 || !fifo_empty) && guard < 20000) begin
            step();
            guard++;
        end
        repeat (24) step();
    endtask

    // Monitor: one sample per bit time, taken after the launching edge.
    initial begin
        bit          in_frame = 1'b0;
        int          idx = 0;
        int          want = 0;
        logic [11:0] got = '0;
        forever begin
            @(posedge clk);
            if (baud_tick) begin
                @(negedge clk);
                if (mon_en) begin
                    if (!in_frame) begin
                        if (serial_out == 1'b0) begin
                            if (exp_len_q.size() == 0) begin
                                check(1'b0, cur_req, "unexpected frame", 1, 0);
                            end else begin
                                got      = '1;
                                got[0]   = 1'b0;
                                idx      = 1;
                                want     = exp_len_q[0];
                                in_frame = 1'b1;
                            end
                        end
                    end else begin
                        got[idx] = serial_out;
                        idx++;
                        if (idx == want) begin
                            check(got == exp_bits_q[0], cur_req, "frame bits",
                                  int'(got), int'(exp_bits_q[0]));
                            void'(exp_bits_q.pop_front());
                            void'(exp_len_q.pop_front());
                            in_frame = 1'b0;
                        end
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int guard;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        check(serial_out == 1'b1, "R1", "line after reset", int'(serial_out), 1);
        check(fifo_empty == 1'b1, "R1", "empty after reset", int'(fifo_empty), 1);
        check(fifo_full == 1'b0, "R1", "full after reset", int'(fifo_full), 0);

        tick_on = 1'b1;
        mon_en  = 1'b1;

        // R2: 8 bits, no parity, one stop, back to back
        cur_req   = "R2";
        mode_cfg  = 8'h20;
        tx_enable = 1'b1;
        put(8'hA5, 1'b1);
        put(8'h3C, 1'b1);
        put(8'h00, 1'b1);
        put(8'hFF, 1'b1);
        drain();

        // R3 and R4: 7 bits, odd parity
        cur_req  = "R3";
        mode_cfg = 8'h0C;
        put(8'h41, 1'b1);
        put(8'h5A, 1'b1);
        drain();

        // R5: 6 bits, even parity, two stop bits
        cur_req  = "R5";
        mode_cfg = 8'h86;
        put(8'h2B, 1'b1);
        drain();
        // R12: upper bits of a 6-bit character are ignored
        cur_req = "R12";
        put(8'hFF, 1'b1);
        put(8'hC0, 1'b1);
        drain();

        // R4: space, mark, and 7-bit mark with two stops
        cur_req  = "R4";
        mode_cfg = 8'h10;
        put(8'h81, 1'b1);
        drain();
        mode_cfg = 8'h18;
        put(8'h81, 1'b1);
        drain();
        mode_cfg = 8'h9C;
        put(8'hC3, 1'b1);
        drain();

        // R10: fill while not enabled, overflow write dropped
        cur_req   = "R10";
        mode_cfg  = 8'h20;
        tx_enable = 1'b0;
        for (int k = 0; k < 16; k++) put(8'(8'h30 + k), 1'b1);
        check(fifo_full == 1'b1, "R10", "full at 16", int'(fifo_full), 1);
        step();
        wr_valid = 1'b1;
        wr_char  = 8'hEE;
        step();
        wr_valid = 1'b0;
        check(fifo_full == 1'b1, "R10", "full after dropped write", int'(fifo_full), 1);

        // R6: disable wins over enable
        cur_req    = "R6";
        tx_enable  = 1'b1;
        tx_disable = 1'b1;
        repeat (32) step();
        check(serial_out == 1'b1, "R6", "line while disabled", int'(serial_out), 1);
        check(fifo_full == 1'b1, "R6", "queue kept while disabled", int'(fifo_full), 1);

        // R11: write on the tick that pops the full queue
        cur_req = "R11";
        guard = 0;
        while (!baud_tick && guard < 20) begin
            step();
            guard++;
        end
        tx_disable = 1'b0;
        begin
            logic [11:0] b;
            int          l;
            wr_valid = 1'b1;
            wr_char  = 8'h77;
            model(8'h77, mode_cfg, b, l);
            exp_bits_q.push_back(b);
            exp_len_q.push_back(l);
        end
        step();
        wr_valid = 1'b0;
        check(fifo_full == 1'b1, "R11", "full after pop plus write", int'(fifo_full), 1);
        drain();
        check(exp_len_q.size() == 0, "R11", "frames outstanding", exp_len_q.size(), 0);

        // R7: disable mid-frame lets the frame finish
        cur_req = "R7";
        put(8'h11, 1'b1);
        put(8'h22, 1'b1);
        guard = 0;
        while (serial_out && guard < 200) begin
            step();
            guard++;
        end
        repeat (24) step();
        tx_disable = 1'b1;
        guard = 0;
        while (exp_len_q.size() > 1 && guard < 400) begin
            step();
            guard++;
        end
        repeat (120) step();
        check(exp_len_q.size() == 1, "R7", "frames left", exp_len_q.size(), 1);
        check(fifo_empty == 1'b0, "R7", "second char still queued", int'(fifo_empty), 0);
        check(serial_out == 1'b1, "R7", "idle after frame", int'(serial_out), 1);
        tx_disable = 1'b0;
        drain();

        // R8: break low, release, simultaneous pulses
        cur_req = "R8";
        mon_en  = 1'b0;
        break_start = 1'b1;
        step();
        break_start = 1'b0;
        check(serial_out == 1'b0, "R8", "line in break", int'(serial_out), 0);
        repeat (24) step();
        check(serial_out == 1'b0, "R8", "break held", int'(serial_out), 0);
        break_stop = 1'b1;
        step();
        break_stop = 1'b0;
        check(serial_out == 1'b1, "R8", "line after break stop", int'(serial_out), 1);
        break_start = 1'b1;
        step();
        break_stop = 1'b1;
        step();
        break_start = 1'b0;
        break_stop  = 1'b0;
        check(serial_out == 1'b1, "R8", "stop wins over start", int'(serial_out), 1);

        // R9: transmit reset clears queue and break
        cur_req   = "R9";
        tx_enable = 1'b0;
        put(8'h01, 1'b0);
        put(8'h02, 1'b0);
        put(8'h03, 1'b0);
        break_start = 1'b1;
        step();
        break_start = 1'b0;
        tx_reset = 1'b1;
        step();
        tx_reset = 1'b0;
        check(fifo_empty == 1'b1, "R9", "queue after reset", int'(fifo_empty), 1);
        check(serial_out == 1'b1, "R9", "line after reset", int'(serial_out), 1);
        repeat (16) step();
        mon_en    = 1'b1;
        tx_enable = 1'b1;
        put(8'h5E, 1'b1);
        drain();
        check(exp_len_q.size() == 0, "R9", "frames outstanding", exp_len_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule